// File: doc/BRIEF.md
# BCD Calendar Clock with SPI Register Access

This block is a real-time calendar kept as packed BCD bytes. A host reaches it through a four-wire serial slave port. Seven time registers hold seconds, minutes, hours, weekday, day of month, month and year. Two control registers sit at the top of the 16-entry address space: one selects the hour format, and the other carries two sticky status flags, one for oscillator stop and one for low supply.

Every transaction opens with a command byte. Its upper nibble names a register and two bits below that pick single or burst access and the transfer direction. One data byte follows a single access. A burst keeps streaming bytes and steps the address after each one. The calendar moves forward by one second on each single-cycle `tick` pulse. The carries run from seconds through minutes, hours, day and month into year, and they follow month lengths and leap years. When the year passes 99, the century flag in the month register is set.

Top module: `rtc_spi_top`

## Requirements
- R1: The command byte carries the register address in bits 7:4. Bits 3:2 give the access type: 2'b10 single write, 2'b11 single read, 2'b00 burst write, 2'b01 burst read. Bits 1:0 are ignored.
- R2: The serial port runs clock-idle-low. The slave updates `spiMiso` after each rising `spiClk` edge and samples `spiMosi` on each falling edge, MSB first. `spiCs` is active high. When `spiCs` drops, the transaction ends, a partly shifted byte is discarded, and `spiMiso` is held at 0.
- R3: A single access transfers exactly one data byte. Further bytes in the same transaction write nothing and read as 0x00.
- R4: In a burst, the address steps by one after each data byte and wraps from 15 to 0.
- R5: The register map is seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6, config 14, status 15. After reset the time bytes read 00, 00, 0x12 (12 AM), 00, 0x01, 0x01, 00.
- R6: Stored widths are seconds and minutes 7 bits, hours 6, weekday 3, day 6, month 5 plus the century flag in bit 7, and year 8. Bits outside these fields read 0, so seconds bit 7 always reads 0.
- R7: Addresses 7 to 13 read as 0x00, and writes to them have no effect.
- R8: Config bit 5 selects 24-hour mode, and reset leaves it clear. In the status register, bit 4 is the oscillator-stop flag and bit 6 is the low-supply flag, and reset sets both. A written 0 in a flag bit clears that flag and a written 1 leaves it as it is. While `supplyLow` is high, the low-supply flag is set.
- R9: On each `tick`, seconds count 00 to 59 in BCD. The wrap from 59 carries into minutes, and minutes wrap from 59 in the same way.
- R10: In 24-hour mode hours run 00 to 23 and carry into the day after 23. In 12-hour mode bit 5 is PM and bits 4:0 hold 12, 01 to 11. 11 turns into 12 with PM toggled, 12 turns into 01, and the day carries on 11 PM to 12 AM.
- R11: The day wraps to 01 after the month's last day, which is 28, 29, 30 or 31. February has 29 days when the BCD year is divisible by 4. The weekday steps 0 to 6 on each day carry. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and sets the century flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial port |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| supplyLow | input | 1 | Sets the low-supply status flag while high |
| spiCs | input | 1 | Chip select, active high |
| spiClk | input | 1 | Serial clock, idle low |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |

## Verification
Directed cases put the counter just before every kind of rollover. These cover the last second of a century in 24-hour mode, the 11 AM, 12 PM and 11 PM hour edges in 12-hour mode, and February in a leap year and in a common year, so each carry path shows up separately. Command patterns pit single against burst access and cover the ignored low command bits, the address wrap, unmapped addresses and an aborted chip select, which separates address stepping from decoding. Random valid dates in both hour formats, each followed by a random run of ticks, are checked against a binary calendar model in the bench. The model converts to BCD only when it compares, so a BCD carry fault inside the counter cannot hide.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_WDAY = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_DAY  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 4'd14;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'd15;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} xferPhase_e;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
  } ctrlStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] lastDay(input logic [4:0] mon, input logic [4:0] yrLow);
    logic leap;
    leap = yrLow[4] ? (yrLow[3:0] == 4'd2 || yrLow[3:0] == 4'd6)
                    : (yrLow[3:0] == 4'd0 || yrLow[3:0] == 4'd4 || yrLow[3:0] == 4'd8);
    case (mon)
      5'h02:                      lastDay = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDay = 6'h30;
      default:                    lastDay = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCs,
  input  logic              spiClk,
  input  logic              spiMosi,
  input  logic [DATA_W-1:0] rdData,
  output ctrlStrobe_t       strobe,
  output logic              spiMiso
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [SYNC_STAGES:0]   clkQ;
  logic [SYNC_STAGES-1:0] csQ;
  logic [SYNC_STAGES-1:0] mosiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ  <= '0;
      csQ   <= '0;
      mosiQ <= '0;
    end else begin
      clkQ  <= {clkQ[SYNC_STAGES-1:0], spiClk};
      csQ   <= {csQ[SYNC_STAGES-2:0], spiCs};
      mosiQ <= {mosiQ[SYNC_STAGES-2:0], spiMosi};
    end
  end

  logic csAct, riseE, fallE, mosiS;
  assign csAct = csQ[SYNC_STAGES-1];
  assign mosiS = mosiQ[SYNC_STAGES-1];
  assign riseE = csAct & clkQ[SYNC_STAGES-1] & ~clkQ[SYNC_STAGES];
  assign fallE = csAct & ~clkQ[SYNC_STAGES-1] & clkQ[SYNC_STAGES];

  xferPhase_e        phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-2:0] shiftIn;
  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] byteIn;
  logic [ADDR_W-1:0] addr;
  logic              isRead, isBurst, misoR, lastBit;

  assign byteIn  = {shiftIn, mosiS};
  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase         <= PH_CMD;
      bitCnt        <= '0;
      shiftIn       <= '0;
      shiftOut      <= '0;
      addr          <= '0;
      isRead        <= 1'b0;
      isBurst       <= 1'b0;
      misoR         <= 1'b0;
      strobe.wrEn   <= 1'b0;
      strobe.wrAddr <= '0;
      strobe.wrData <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (!csAct) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
        misoR  <= 1'b0;
      end else begin
        if (riseE) begin
          if (phase == PH_DATA && isRead) begin
            if (bitCnt == '0) begin
              misoR    <= rdData[DATA_W-1];
              shiftOut <= {rdData[DATA_W-2:0], 1'b0};
            end else begin
              misoR    <= shiftOut[DATA_W-1];
              shiftOut <= {shiftOut[DATA_W-2:0], 1'b0};
            end
          end else begin
            misoR <= 1'b0;
          end
        end
        if (fallE) begin
          shiftIn <= byteIn[DATA_W-2:0];
          bitCnt  <= bitCnt + 1'b1;
          if (lastBit) begin
            case (phase)
              PH_CMD: begin
                addr    <= byteIn[7:4];
                isRead  <= byteIn[2];
                isBurst <= ~byteIn[3];
                phase   <= PH_DATA;
              end
              PH_DATA: begin
                if (!isRead) begin
                  strobe.wrEn   <= 1'b1;
                  strobe.wrAddr <= addr;
                  strobe.wrData <= byteIn;
                end
                if (isBurst) addr  <= addr + 1'b1;
                else         phase <= PH_DONE;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign strobe.rdAddr = addr;
  assign spiMiso       = misoR & csAct;
endmodule

// File: rtl/rtc_time_dp.sv
module rtc_time_dp
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              supplyLow,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);
  logic [6:0] secR, minR;
  logic [5:0] hourR, dayR;
  logic [2:0] wdayR;
  logic [4:0] monR;
  logic [7:0] yearR;
  logic       centR, mode24, oscStop, voltLow;

  logic [6:0] secInc, minInc;
  logic [5:0] dayInc, hourInc24;
  logic [4:0] monInc, hourInc12;
  logic [7:0] yearInc;

  assign secInc    = 7'(bcdInc({1'b0, secR}));
  assign minInc    = 7'(bcdInc({1'b0, minR}));
  assign hourInc24 = 6'(bcdInc({2'b0, hourR}));
  assign hourInc12 = 5'(bcdInc({3'b0, hourR[4:0]}));
  assign dayInc    = 6'(bcdInc({2'b0, dayR}));
  assign monInc    = 5'(bcdInc({3'b0, monR}));
  assign yearInc   = bcdInc(yearR);

  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;
  logic minStep, hourStep, dayStep, monStep, yearStep;
  logic [6:0] nSec, nMin;
  logic [5:0] nHour, nDay;
  logic [2:0] nWday;
  logic [4:0] nMon;
  logic [7:0] nYear;
  logic       nCent;

  always_comb begin
    secWrap  = secR >= 7'h59;
    minWrap  = minR >= 7'h59;
    minStep  = secWrap;
    hourStep = minStep & minWrap;
    nSec     = secWrap ? 7'h00 : secInc;
    nMin     = minStep ? (minWrap ? 7'h00 : minInc) : minR;

    if (mode24) begin
      hourWrap = hourR >= 6'h23;
      nHour    = hourWrap ? 6'h00 : hourInc24;
    end else if (hourR[4:0] >= 5'h12) begin
      hourWrap = 1'b0;
      nHour    = {hourR[5], 5'h01};
    end else if (hourR[4:0] == 5'h11) begin
      hourWrap = hourR[5];
      nHour    = {~hourR[5], 5'h12};
    end else begin
      hourWrap = 1'b0;
      nHour    = {hourR[5], hourInc12};
    end
    if (!hourStep) nHour = hourR;

    dayStep  = hourStep & hourWrap;
    dayWrap  = dayR >= lastDay(monR, yearR[4:0]);
    nDay     = dayStep ? (dayWrap ? 6'h01 : dayInc) : dayR;
    nWday    = dayStep ? ((wdayR >= 3'd6) ? 3'd0 : wdayR + 3'd1) : wdayR;

    monStep  = dayStep & dayWrap;
    monWrap  = monR >= 5'h12;
    nMon     = monStep ? (monWrap ? 5'h01 : monInc) : monR;

    yearStep = monStep & monWrap;
    yearWrap = yearR >= 8'h99;
    nYear    = yearStep ? (yearWrap ? 8'h00 : yearInc) : yearR;
    nCent    = centR | (yearStep & yearWrap);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR    <= '0;
      minR    <= '0;
      hourR   <= 6'h12;
      wdayR   <= '0;
      dayR    <= 6'h01;
      monR    <= 5'h01;
      yearR   <= '0;
      centR   <= 1'b0;
      mode24  <= 1'b0;
      oscStop <= 1'b1;
      voltLow <= 1'b1;
    end else begin
      if (tick) begin
        secR  <= nSec;
        minR  <= nMin;
        hourR <= nHour;
        wdayR <= nWday;
        dayR  <= nDay;
        monR  <= nMon;
        yearR <= nYear;
        centR <= nCent;
      end
      if (strobe.wrEn) begin
        case (strobe.wrAddr)
          ADR_SEC:  secR  <= strobe.wrData[6:0];
          ADR_MIN:  minR  <= strobe.wrData[6:0];
          ADR_HOUR: hourR <= strobe.wrData[5:0];
          ADR_WDAY: wdayR <= strobe.wrData[2:0];
          ADR_DAY:  dayR  <= strobe.wrData[5:0];
          ADR_MON: begin
            monR  <= strobe.wrData[4:0];
            centR <= strobe.wrData[7];
          end
          ADR_YEAR: yearR  <= strobe.wrData;
          ADR_CFG:  mode24 <= strobe.wrData[5];
          ADR_STAT: begin
            oscStop <= oscStop & strobe.wrData[4];
            voltLow <= voltLow & strobe.wrData[6];
          end
          default: ;
        endcase
      end
      if (supplyLow) voltLow <= 1'b1;
    end
  end

  always_comb begin
    case (strobe.rdAddr)
      ADR_SEC:  rdData = {1'b0, secR};
      ADR_MIN:  rdData = {1'b0, minR};
      ADR_HOUR: rdData = {2'b0, hourR};
      ADR_WDAY: rdData = {5'b0, wdayR};
      ADR_DAY:  rdData = {2'b0, dayR};
      ADR_MON:  rdData = {centR, 2'b0, monR};
      ADR_YEAR: rdData = yearR;
      ADR_CFG:  rdData = {2'b0, mode24, 5'b0};
      ADR_STAT: rdData = {1'b0, voltLow, 1'b0, oscStop, 4'b0};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_spi_top.sv
module rtc_spi_top
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic supplyLow,
  input  logic spiCs,
  input  logic spiClk,
  input  logic spiMosi,
  output logic spiMiso
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] rdData;

  rtc_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiCs(spiCs), .spiClk(spiClk), .spiMosi(spiMosi),
    .rdData(rdData), .strobe(strobe), .spiMiso(spiMiso)
  );

  rtc_time_dp u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .supplyLow(supplyLow),
    .strobe(strobe), .rdData(rdData)
  );
endmodule

// File: rtl/rtc_spi_chk.sv
module rtc_spi_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              supplyLow,
  input logic              wrEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn); // R4
  AST_SEC_MSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADR_SEC) |-> !rdData[7]); // R6
  AST_MONTH_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADR_MON) |-> (rdData[6:5] == 2'b00)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr inside {[4'd7:4'd13]}) |-> (rdData == '0)); // R7
  AST_VLOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> (rdAddr != ADR_STAT || rdData[6])); // R8
endmodule

bind rtc_spi_top rtc_spi_chk u_chk (
  .clk(clk), .rstN(rstN), .supplyLow(supplyLow),
  .wrEn(strobe.wrEn), .rdAddr(strobe.rdAddr), .rdData(rdData)
);

// File: tb/sim_rtc_spi_top.sv
`timescale 1ns/1ps
module sim_rtc_spi_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, supplyLow = 1'b0;
  logic spiCs = 1'b0, spiClk = 1'b0, spiMosi = 1'b0;
  logic spiMiso;

  always #2.5 clk = ~clk;

  rtc_spi_top u0 (.clk(clk), .rstN(rstN), .tick(tick), .supplyLow(supplyLow),
    .spiCs(spiCs), .spiClk(spiClk), .spiMosi(spiMosi), .spiMiso(spiMiso));

  int nChecks = 0, nErrs = 0;
  bit finished = 1'b0;
  logic [7:0] rxB;
  logic [7:0] rdBuf [16];
  logic [7:0] wrBuf [16];

  // binary calendar model
  int mSec, mMin, mHour, mWday, mDay, mMon, mYear, mCent, m24;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expByte(input int idx);
    case (idx)
      0: return toBcd(mSec);
      1: return toBcd(mMin);
      2: return (m24 != 0) ? toBcd(mHour)
                           : (toBcd((mHour + 11) % 12 + 1) | ((mHour >= 12) ? 8'h20 : 8'h00));
      3: return toBcd(mWday);
      4: return toBcd(mDay);
      5: return toBcd(mMon) | ((mCent != 0) ? 8'h80 : 8'h00);
      default: return toBcd(mYear);
    endcase
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0; mWday = (mWday + 1) % 7; mDay++;
          if (mDay > daysIn(mMon, mYear)) begin
            mDay = 1; mMon++;
            if (mMon > 12) begin
              mMon = 1; mYear++;
              if (mYear == 100) begin mYear = 0; mCent = 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); spiClk = 1'b1; spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spiMiso;
      spiClk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic csOn();
    @(negedge clk); spiCs = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (4) @(negedge clk); spiCs = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic burstWrite(input int a, input int n);
    logic [7:0] d;
    csOn(); xferByte({4'(a), 4'h0}, d);
    for (int k = 0; k < n; k++) xferByte(wrBuf[k], d);
    csOff();
  endtask

  task automatic burstRead(input int a, input int n);
    logic [7:0] d;
    csOn(); xferByte({4'(a), 4'h4}, d);
    for (int k = 0; k < n; k++) begin xferByte(8'h00, d); rdBuf[k] = d; end
    csOff();
  endtask

  task automatic singleWrite(input int a, input logic [7:0] v);
    logic [7:0] d;
    csOn(); xferByte({4'(a), 4'h8}, d); xferByte(v, d); csOff();
  endtask

  task automatic singleRead(input int a, output logic [7:0] v);
    logic [7:0] d;
    csOn(); xferByte({4'(a), 4'hC}, d); xferByte(8'h00, v); csOff();
  endtask

  task automatic loadModel();
    singleWrite(14, (m24 != 0) ? 8'h20 : 8'h00);
    for (int k = 0; k < 7; k++) wrBuf[k] = expByte(k);
    burstWrite(0, 7);
  endtask

  task automatic verifyAll(input string req);
    burstRead(0, 7);
    for (int k = 0; k < 7; k++) check(req, rdBuf[k], expByte(k));
  endtask

  task automatic pulseTick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
      modelTick();
    end
  endtask

  task automatic setModel(input int t24, input int h, input int mi, input int s, input int wd,
                          input int dy, input int mo, input int yr, input int ce);
    m24 = t24; mHour = h; mMin = mi; mSec = s; mWday = wd;
    mDay = dy; mMon = mo; mYear = yr; mCent = ce;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErrs++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk); rstN = 1'b1; repeat (3) @(negedge clk);

    // R5 reset values, R8 flags set
    setModel(0, 0, 0, 0, 0, 1, 1, 0, 0);
    verifyAll("R5 reset time");
    singleRead(15, v); check("R8 reset status flags", v, 8'h50);
    singleRead(14, v); check("R8 reset config 12h", v, 8'h00);

    // R6 field masks
    singleWrite(0, 8'hFF); singleRead(0, v); check("R6 seconds bit7 zero", v, 8'h7F);
    singleWrite(2, 8'hFF); singleRead(2, v); check("R6 hour mask", v, 8'h3F);
    singleWrite(3, 8'hFF); singleRead(3, v); check("R6 weekday mask", v, 8'h07);
    singleWrite(5, 8'hFF); singleRead(5, v); check("R6 month mask", v, 8'h9F);

    // R7 unmapped
    singleWrite(9, 8'hAA); singleRead(9, v); check("R7 unmapped reads zero", v, 8'h00);
    singleRead(13, v); check("R7 unmapped 13", v, 8'h00);

    // R3 single access stops after one byte
    singleWrite(2, 8'h05);
    csOn(); xferByte(8'h18, d); xferByte(8'h34, d); xferByte(8'h56, d); csOff();
    singleRead(1, v); check("R3 single write first byte", v, 8'h34);
    singleRead(2, v); check("R3 extra byte ignored", v, 8'h05);
    csOn(); xferByte(8'h1C, d); xferByte(8'h00, v); xferByte(8'h00, d); csOff();
    check("R3 single read byte", v, 8'h34);
    check("R3 read after single is zero", d, 8'h00);

    // R1 low command bits ignored
    csOn(); xferByte(8'h1F, d); xferByte(8'h00, v); csOff();
    check("R1 low bits ignored", v, 8'h34);

    // R4 burst wrap, R8 flags
    wrBuf[0] = 8'h20; wrBuf[1] = 8'hFF; wrBuf[2] = 8'h45;
    burstWrite(14, 3);
    burstRead(14, 3);
    check("R4 burst cfg", rdBuf[0], 8'h20);
    check("R4 burst status kept by ones R8", rdBuf[1], 8'h50);
    check("R4 wrap to seconds", rdBuf[2], 8'h45);
    singleWrite(15, 8'h10); singleRead(15, v); check("R8 clear low-supply only", v, 8'h10);
    singleWrite(15, 8'h00); singleRead(15, v); check("R8 clear both", v, 8'h00);
    @(negedge clk); supplyLow = 1'b1; @(negedge clk); supplyLow = 1'b0;
    singleRead(15, v); check("R8 supplyLow sets flag", v, 8'h40);

    // R2 abort mid-byte and idle miso
    csOn(); xferByte(8'h00, d);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); spiClk = 1'b1; spiMosi = 1'b1;
      repeat (HALF) @(negedge clk); spiClk = 1'b0; repeat (HALF) @(negedge clk);
    end
    csOff();
    check("R2 miso low while deselected", {7'b0, spiMiso}, 8'h00);
    singleRead(0, v); check("R2 aborted byte not written", v, 8'h45);

    // R9 R10 R11 directed rollovers
    setModel(1, 23, 59, 59, 6, 31, 12, 99, 0); loadModel(); pulseTick(1);
    verifyAll("R11 century rollover 24h R9 R10");
    setModel(0, 11, 59, 59, 2, 10, 5, 30, 1); loadModel(); pulseTick(1);
    verifyAll("R10 11AM to 12PM");
    setModel(0, 12, 59, 59, 2, 10, 5, 30, 1); loadModel(); pulseTick(1);
    verifyAll("R10 12PM to 1PM");
    setModel(0, 23, 59, 59, 2, 10, 5, 30, 1); loadModel(); pulseTick(1);
    verifyAll("R10 11PM to 12AM");
    setModel(1, 23, 59, 59, 1, 28, 2, 23, 1); loadModel(); pulseTick(1);
    verifyAll("R11 Feb common year");
    setModel(1, 23, 59, 59, 1, 28, 2, 24, 1); loadModel(); pulseTick(1);
    verifyAll("R11 Feb leap year");
    setModel(1, 23, 59, 59, 4, 30, 4, 7, 0); loadModel(); pulseTick(1);
    verifyAll("R11 30-day month");
    setModel(1, 0, 0, 55, 0, 1, 1, 0, 0); loadModel(); pulseTick(10);
    verifyAll("R9 seconds carry");

    // random dates and tick runs
    for (int it = 0; it < 20; it++) begin
      int mo, yr;
      mo = 1 + int'($urandom % 12); yr = int'($urandom % 100);
      setModel(int'($urandom % 2), int'($urandom % 24), 55 + int'($urandom % 5),
               int'($urandom % 60), int'($urandom % 7),
               daysIn(mo, yr) - int'($urandom % 2), mo, yr, int'($urandom % 2));
      loadModel();
      pulseTick(1 + int'($urandom % 400));
      verifyAll("R9 R10 R11 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule